// File: doc/BRIEF.md
# Bus Clock Ratio Divider

This block turns one of two source clock-enable streams into three related bus clock enables: a fast bus enable, a mid bus enable and a peripheral bus enable. Everything runs in the source clock domain. Each source stream is a one-cycle-per-pulse enable that stands in for a PLL output. The outputs are one-cycle enable pulses, not clocks. Downstream logic gates its registers with them.

A single 16-bit configuration word sets the source choice and all three ratios. The fast enable divides the chosen source by the product of two programmable factors. The mid and peripheral enables divide the fast enable by restricted ratios, so they only ever fire on a fast-enable cycle.

A configuration write is held back until the next point where all dividers complete their periods together. There the new ratios load with every counter at zero, so no shortened pulse appears. A word carrying a reserved code is rejected and sets a sticky error flag.

Top module: `bus_ratio_div`

## Requirements
- R1: While reset is low, and in the cycle after it is released, fastEn, midEn, perEn and cfgErr are 0. The active configuration resets to all-zero: source 0, and every ratio equal to 1.
- R2: fastEn is asserted once for every (pre+1)*(mul+1) pulses of the selected source. The field pre is cfgData[7:3] and mul is cfgData[2:0]. fastEn appears in the cycle after the clock edge that samples the completing source pulse.
- R3: The mid field cfgData[9:8] selects how many fastEn pulses make one midEn pulse: code 0 gives 1, code 1 gives 2 and code 3 gives 4. midEn is only ever high in a cycle where fastEn is high.
- R4: The peripheral field cfgData[14:12], holding a value p from 0 to 6, gives one perEn pulse for every p+1 fastEn pulses. perEn is only ever high in a cycle where fastEn is high.
- R5: A legal write (cfgWe high) is held pending. It becomes active right after the common boundary: the selected-source pulse at which the fast, mid and peripheral periods all complete together. A second legal write made before that boundary replaces the first.
- R6: A write is illegal if it has mid code 2, peripheral code 7, or a nonzero value in cfgData[11:10]. An illegal write sets cfgErr in the following cycle. cfgErr then stays set until reset.
- R7: An illegal write changes neither the pending nor the active configuration. The output pulse pattern continues as if the write had not occurred.
- R8: cfgData[15] selects the source: 0 uses srcEn0 and 1 uses srcEn1. Pulses on the stream that is not selected have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source-domain clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEn0 | input | 1 | Enable pulse stream of source 0 |
| srcEn1 | input | 1 | Enable pulse stream of source 1 |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 16 | Configuration word |
| fastEn | output | 1 | Fast bus clock enable |
| midEn | output | 1 | Mid bus clock enable |
| perEn | output | 1 | Peripheral bus clock enable |
| cfgErr | output | 1 | Sticky reserved-code error flag |

## Verification
The assertions assume the following about the inputs:
- The active configuration only ever holds legal codes, since the control rejects reserved ones.
- The selected source keeps producing pulses, because a pending write is applied only when the source reaches the next common boundary.

The stimulus respects both assumptions. Both source streams toggle pseudo-randomly at a high duty in every phase. The bench waits for its own model to report that each pending word has been applied before it measures a ratio. Reserved codes are written only in a dedicated phase, where the flag and the unchanged pulse pattern are checked.

// File: rtl/busdiv_pkg.sv
`timescale 1ns/1ps
package busdiv_pkg;
  localparam int CFG_W     = 16;
  localparam int SEL_BIT   = 15;
  localparam int PRE_LSB   = 3;
  localparam int PRE_W     = 5;
  localparam int MUL_LSB   = 0;
  localparam int MUL_W     = 3;
  localparam int MID_LSB   = 8;
  localparam int MID_W     = 2;
  localparam int SPARE_LSB = 10;
  localparam int SPARE_W   = 2;
  localparam int PER_LSB   = 12;
  localparam int PER_W     = 3;

  localparam logic [MID_W-1:0] MID_RSVD = MID_W'(2);
  localparam logic [PER_W-1:0] PER_RSVD = {PER_W{1'b1}};

  // Strobe/limit bundle from control to datapath. Limits are ratio-1.
  typedef struct packed {
    logic             sel;
    logic [PRE_W-1:0] pre;
    logic [MUL_W-1:0] mul;
    logic [MID_W-1:0] mid;
    logic [PER_W-1:0] per;
  } ratioCfgT;
endpackage

// File: rtl/ratio_ctr.sv
`timescale 1ns/1ps
module ratio_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         adv,
  input  logic [W-1:0] lim,
  output logic         wrap
);
  logic [W-1:0] cnt;

  assign wrap = adv && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rstN)     cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (adv)  cnt <= cnt + 1'b1;
  end

  // Limits only change at a common boundary, when every count is zero.
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lim); // R5
endmodule

// File: rtl/busdiv_ctrl.sv
`timescale 1ns/1ps
module busdiv_ctrl
  import busdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             boundary,
  output ratioCfgT         activeCfg,
  output logic             cfgErr
);
  ratioCfgT wrCfg;
  ratioCfgT pendCfg;
  logic     pendValid;
  logic     wrLegal;

  always_comb begin
    wrCfg.sel = cfgData[SEL_BIT];
    wrCfg.pre = cfgData[PRE_LSB +: PRE_W];
    wrCfg.mul = cfgData[MUL_LSB +: MUL_W];
    wrCfg.mid = cfgData[MID_LSB +: MID_W];
    wrCfg.per = cfgData[PER_LSB +: PER_W];
    wrLegal   = (wrCfg.mid != MID_RSVD) && (wrCfg.per != PER_RSVD)
                && (cfgData[SPARE_LSB +: SPARE_W] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCfg <= '0;
      pendCfg   <= '0;
      pendValid <= 1'b0;
      cfgErr    <= 1'b0;
    end else begin
      if (boundary && pendValid) begin
        activeCfg <= pendCfg;
        pendValid <= 1'b0;
      end
      if (cfgWe) begin
        if (wrLegal) begin
          pendCfg   <= wrCfg;
          pendValid <= 1'b1;
        end else begin
          cfgErr <= 1'b1;
        end
      end
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgErr) |-> cfgErr); // R6
  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (activeCfg != $past(activeCfg)) |-> $past(boundary)); // R5
  AST_MID_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (activeCfg.mid != MID_RSVD) && (activeCfg.per != PER_RSVD)); // R7
endmodule

// File: rtl/busdiv_datapath.sv
`timescale 1ns/1ps
module busdiv_datapath
  import busdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     srcEn0,
  input  logic     srcEn1,
  input  ratioCfgT cfg,
  output logic     boundary,
  output logic     fastEn,
  output logic     midEn,
  output logic     perEn
);
  logic tick;
  logic preWrap;
  logic fastWrap;
  logic midWrap;
  logic perWrap;

  assign tick = cfg.sel ? srcEn1 : srcEn0;

  ratio_ctr #(.W(PRE_W)) i_preCtr (
    .clk(clk), .rstN(rstN), .adv(tick), .lim(cfg.pre), .wrap(preWrap));
  ratio_ctr #(.W(MUL_W)) i_mulCtr (
    .clk(clk), .rstN(rstN), .adv(preWrap), .lim(cfg.mul), .wrap(fastWrap));
  ratio_ctr #(.W(MID_W)) i_midCtr (
    .clk(clk), .rstN(rstN), .adv(fastWrap), .lim(cfg.mid), .wrap(midWrap));
  ratio_ctr #(.W(PER_W)) i_perCtr (
    .clk(clk), .rstN(rstN), .adv(fastWrap), .lim(cfg.per), .wrap(perWrap));

  assign boundary = midWrap && perWrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastEn <= 1'b0;
      midEn  <= 1'b0;
      perEn  <= 1'b0;
    end else begin
      fastEn <= fastWrap;
      midEn  <= midWrap;
      perEn  <= perWrap;
    end
  end

  AST_MID_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    midEn |-> fastEn); // R3
  AST_PER_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    perEn |-> fastEn); // R4
  AST_FAST_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    fastEn |-> ($past(srcEn0) || $past(srcEn1))); // R2
endmodule

// File: rtl/bus_ratio_div.sv
`timescale 1ns/1ps
module bus_ratio_div
  import busdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcEn0,
  input  logic             srcEn1,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  output logic             fastEn,
  output logic             midEn,
  output logic             perEn,
  output logic             cfgErr
);
  ratioCfgT activeCfg;
  logic     boundary;

  busdiv_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .boundary(boundary), .activeCfg(activeCfg), .cfgErr(cfgErr));

  busdiv_datapath i_datapath (
    .clk(clk), .rstN(rstN), .srcEn0(srcEn0), .srcEn1(srcEn1),
    .cfg(activeCfg), .boundary(boundary),
    .fastEn(fastEn), .midEn(midEn), .perEn(perEn));
endmodule

// File: tb/test_bus_ratio_div.sv
`timescale 1ns/1ps
module test_bus_ratio_div;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic srcEn0 = 1'b0, srcEn1 = 1'b0, cfgWe = 1'b0;
  logic [15:0] cfgData = '0;
  logic fastEn, midEn, perEn, cfgErr;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  // Reference model state
  logic [15:0] act = '0, pend = '0;
  bit pendV = 0;
  int k = 0;
  bit expF = 0, expM = 0, expP = 0, expE = 0;

  always #2 clk = ~clk;

  bus_ratio_div i_bus_ratio_div (
    .clk(clk), .rstN(rstN), .srcEn0(srcEn0), .srcEn1(srcEn1),
    .cfgWe(cfgWe), .cfgData(cfgData),
    .fastEn(fastEn), .midEn(midEn), .perEn(perEn), .cfgErr(cfgErr));

  function automatic int rF(logic [15:0] c);
    return (int'(c[7:3]) + 1) * (int'(c[2:0]) + 1);
  endfunction
  function automatic int rM(logic [15:0] c);
    return (c[9:8] == 2'd0) ? 1 : (c[9:8] == 2'd1) ? 2 : 4;
  endfunction
  function automatic int rP(logic [15:0] c);
    return int'(c[14:12]) + 1;
  endfunction
  function automatic int lcm(int a, int b);
    int x = a, y = b, t;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return a * b / x;
  endfunction
  function automatic bit legal(logic [15:0] d);
    return (d[9:8] != 2'd2) && (d[14:12] != 3'd7) && (d[11:10] == 2'd0);
  endfunction

  task automatic chk(input logic actual, input logic expv, input string what);
    checks++;
    if (actual !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", phase, what, actual, expv);
    end
  endtask

  // One cycle: check outputs of previous edge, drive new inputs, advance model.
  task automatic cyc(input bit a, input bit b, input bit we, input logic [15:0] d);
    bit tick;
    int f, m, p;
    @(negedge clk);
    chk(fastEn, expF, "fastEn R2");
    chk(midEn, expM, "midEn R3");
    chk(perEn, expP, "perEn R4");
    chk(cfgErr, expE, "cfgErr R6");
    srcEn0 = a; srcEn1 = b; cfgWe = we; cfgData = d;
    tick = act[15] ? b : a;  // R8
    expF = 0; expM = 0; expP = 0;
    if (tick) begin
      f = rF(act); m = rM(act); p = rP(act);
      k++;
      expF = (k % f) == 0;
      expM = (k % (f * m)) == 0;
      expP = (k % (f * p)) == 0;
      if ((k % (f * lcm(m, p))) == 0) begin  // R5 common boundary
        k = 0;
        if (pendV) begin act = pend; pendV = 0; end
      end
    end
    if (we) begin
      if (legal(d)) begin pend = d; pendV = 1; end
      else expE = 1;  // R7: model keeps pend/act
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      cyc(($urandom % 3) != 0, ($urandom % 4) != 0, 1'b0, 16'h0);
  endtask

  task automatic applyCfg(input logic [15:0] d);
    int guard = 0;
    cyc(($urandom % 3) != 0, ($urandom % 4) != 0, 1'b1, d);
    while (pendV && guard < 4000) begin idle(1); guard++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int idx = 0;
    logic [15:0] d;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(fastEn, 1'b0, "R1 fastEn");
    chk(midEn, 1'b0, "R1 midEn");
    chk(perEn, 1'b0, "R1 perEn");
    chk(cfgErr, 1'b0, "R1 cfgErr");
    rstN = 1'b1;

    // R1 R2 R8: reset config, source 0, every ratio 1
    phase = "R1 R2 R8 reset-config";
    idle(200);

    // R2 R3 R4 R5 R8: near-exhaustive sweep of a small ratio set
    phase = "R2 R3 R4 R5 R8 sweep";
    for (int pre = 0; pre < 3; pre++)
      for (int mul = 0; mul < 2; mul++)
        for (int mc = 0; mc < 3; mc++)
          for (int per = 0; per < 7; per++) begin
            d = '0;
            d[15]    = idx[0];
            d[7:3]   = 5'(pre);
            d[2:0]   = 3'(mul);
            d[9:8]   = (mc == 2) ? 2'd3 : 2'(mc);
            d[14:12] = 3'(per);
            applyCfg(d);
            idle(3 * rF(act) * lcm(rM(act), rP(act)));
            idx++;
          end

    // R5: two writes before a boundary, the later one wins
    phase = "R5 overwrite";
    applyCfg(16'h6018);  // pre=3, mid 1:1, per 7 fast
    cyc(1'b1, 1'b1, 1'b1, 16'h8109);
    cyc(1'b1, 1'b1, 1'b1, 16'h1302);
    idle(800);

    // R6 R7: reserved codes flagged and ignored
    phase = "R6 R7 reserved mid";
    cyc(1'b1, 1'b0, 1'b1, 16'h0208);
    idle(300);
    phase = "R6 R7 reserved per";
    cyc(1'b1, 1'b0, 1'b1, 16'h7000);
    idle(300);
    phase = "R6 R7 spare bits";
    cyc(1'b0, 1'b1, 1'b1, 16'h0400);
    idle(300);

    // R8: only the unselected stream pulses
    phase = "R8 unselected ignored";
    applyCfg(16'h8000);
    for (int i = 0; i < 100; i++) cyc(1'b1, 1'b0, 1'b0, 16'h0);
    idle(50);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule